// File: doc/BRIEF.md
# Address-Match Contention Arbiter

This block sits beside a two-port shared memory. It watches each port's enable, address and request-start strobe. When both ports are enabled on the same location, it grants the location to one port. The other port gets an active-low busy line, and that line also acts as the port's write inhibit. The memory array and the pad drivers are outside the block. Its outputs feed the two ports' control logic and, where a wider word is built from several memories, the busy inputs of the companion slices.

Both ports are sampled on every clock. A port "arrives" in a cycle when its enable rises, when its address changes while it is enabled, or when it pulses its request-start strobe while enabled. When a match first appears, the port that arrived in an earlier cycle wins. If both arrived in the same cycle, a fixed tie-break picks the winner (the left port by default). The grant stays in place while the match lasts. A one-cycle flag marks the start of each new contention. All outputs are registered: they reflect the inputs sampled at the previous rising edge.

Top module: `contention_arbiter`

## Requirements
- R1: Both busy outputs are 1 after any edge at which either enable was 0 or the two addresses differed.
- R2: The two busy outputs are never 0 at the same time.
- R3: When a match first appears, the port that arrived in an earlier cycle wins, and the other port's busy output is 0 after that edge.
- R4: A contention can start in two ways: one port's enable rises while the addresses are already equal, or one port's address changes to equal the other's while both are enabled.
- R5: A port arrives in a cycle when its enable rises, its address changes while it is enabled, or its start strobe is 1 while it is enabled. If both ports arrive in the cycle where the match appears, the left port wins (TIE_LEFT=1), so the right busy output is 0.
- R6: The loser's busy output returns to 1 after the first edge at which the addresses differ or either enable is 0.
- R7: While the match holds at every edge, the grant does not change, even when either port pulses its start strobe or both addresses move together to a new equal value.
- R8: The contention flag is 1 for exactly one cycle, after the edge at which a new contention begins. It is 0 while a held contention continues.
- R9: During reset both busy outputs are 1 and the flag is 0. If a match is present at the first edge after reset, it is treated as a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_en | input | 1 | Left port enable, active high |
| lt_addr | input | ADDR_W | Left port address |
| lt_start | input | 1 | Left port request-start strobe |
| rt_en | input | 1 | Right port enable, active high |
| rt_addr | input | ADDR_W | Right port address |
| rt_start | input | 1 | Right port request-start strobe |
| lt_busy_n | output | 1 | Left port busy, active low; also inhibits left writes |
| rt_busy_n | output | 1 | Right port busy, active low; also inhibits right writes |
| clash_pulse | output | 1 | One-cycle flag at the start of each new contention |

## Verification
The properties assume that enables, addresses and strobes are synchronous to the clock and steady around each rising edge. They also assume that "first" is decided only at clock granularity, so two arrivals in the same cycle count as a tie. The bench therefore changes all inputs on falling edges and reads outputs on the following falling edge, one register stage after the edge that sampled them. Its sequences put arrivals in separate cycles for the ordered cases and in the same cycle for the ties. Reset is also asserted in the middle of a held contention, with the match left standing across its release.

// File: rtl/cma_pkg.sv
package cma_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   lt_busy_n;
        logic   rt_busy_n;
        logic   clash;
    } grant_state_t;

    localparam grant_state_t GRANT_IDLE = '{
        owner:     OWN_NONE,
        lt_busy_n: 1'b1,
        rt_busy_n: 1'b1,
        clash:     1'b0
    };

endpackage

// File: rtl/cma_port_watch.sv
// Tracks one port's last sampled enable and address and reports
// whether the port presents a fresh request in the current cycle.
module cma_port_watch #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              start,
    output logic              arrived
);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } seen_t;

    seen_t seen_d, seen_q;
    logic  en_rise;
    logic  addr_moved;

    always_comb begin
        seen_d      = seen_q;
        seen_d.en   = en;
        seen_d.addr = en ? addr : seen_q.addr;
        en_rise     = en && !seen_q.en;
        addr_moved  = en && seen_q.en && (addr != seen_q.addr);
        arrived     = en_rise || addr_moved || (en && start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_d;
        end
    end

endmodule

// File: rtl/cma_match.sv
// Same-location detector: both enabled and addresses equal.
module cma_match #(
    parameter int ADDR_W = 11
) (
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    output logic              hit
);

    logic both_on;
    logic same_loc;

    always_comb begin
        both_on  = lt_en && rt_en;
        same_loc = (lt_addr == rt_addr);
        hit      = both_on && same_loc;
    end

endmodule

// File: rtl/cma_grant.sv
// Ownership state: picks a winner when a match appears and holds it
// until the match is gone.
module cma_grant
    import cma_pkg::*;
#(
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic lt_arrived,
    input  logic rt_arrived,
    output logic lt_busy_n,
    output logic rt_busy_n,
    output logic clash_pulse
);

    grant_state_t st_d, st_q;
    owner_e       tie_owner;
    owner_e       pick;

    generate
        if (TIE_LEFT) begin : g_tie_left
            assign tie_owner = OWN_LEFT;
        end else begin : g_tie_right
            assign tie_owner = OWN_RIGHT;
        end
    endgenerate

    always_comb begin
        // The port that did not arrive this cycle was already waiting.
        unique case ({lt_arrived, rt_arrived})
            2'b10:   pick = OWN_RIGHT;
            2'b01:   pick = OWN_LEFT;
            default: pick = tie_owner;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.clash = 1'b0;
        if (!hit) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            st_d.owner = pick;
            st_d.clash = 1'b1;
        end
        st_d.lt_busy_n = (st_d.owner != OWN_RIGHT);
        st_d.rt_busy_n = (st_d.owner != OWN_LEFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GRANT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lt_busy_n   = st_q.lt_busy_n;
    assign rt_busy_n   = st_q.rt_busy_n;
    assign clash_pulse = st_q.clash;

endmodule

// File: rtl/contention_arbiter.sv
module contention_arbiter #(
    parameter int ADDR_W   = 11,
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_start,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_start,
    output logic              lt_busy_n,
    output logic              rt_busy_n,
    output logic              clash_pulse
);

    localparam int NPORT = 2;

    logic [NPORT-1:0]             en_v;
    logic [NPORT-1:0]             start_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0]             arrived_v;
    logic                         hit;

    assign en_v    = {rt_en, lt_en};
    assign start_v = {rt_start, lt_start};
    assign addr_v  = {rt_addr, lt_addr};

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            cma_port_watch #(.ADDR_W(ADDR_W)) u_watch (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_v[p]),
                .addr    (addr_v[p]),
                .start   (start_v[p]),
                .arrived (arrived_v[p])
            );
        end
    endgenerate

    cma_match #(.ADDR_W(ADDR_W)) u_match (
        .lt_en   (lt_en),
        .lt_addr (lt_addr),
        .rt_en   (rt_en),
        .rt_addr (rt_addr),
        .hit     (hit)
    );

    cma_grant #(.TIE_LEFT(TIE_LEFT)) u_grant (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .lt_arrived  (arrived_v[0]),
        .rt_arrived  (arrived_v[1]),
        .lt_busy_n   (lt_busy_n),
        .rt_busy_n   (rt_busy_n),
        .clash_pulse (clash_pulse)
    );

endmodule

// File: rtl/contention_arbiter_chk.sv
module contention_arbiter_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_en,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              rt_en,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              lt_busy_n,
    input logic              rt_busy_n,
    input logic              clash_pulse
);

    logic same_now;
    assign same_now = lt_en && rt_en && (lt_addr == rt_addr);

    p_never_both_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lt_busy_n && !rt_busy_n));

    p_busy_needs_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !same_now |=> (lt_busy_n && rt_busy_n));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_busy_n && !same_now) |=> rt_busy_n);

    p_hold_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_busy_n && same_now) |=> !rt_busy_n);

    p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lt_busy_n && same_now) |=> !lt_busy_n);

    p_flag_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clash_pulse |=> !clash_pulse);

    p_flag_with_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clash_pulse |-> (lt_busy_n != rt_busy_n));

endmodule

bind contention_arbiter contention_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lt_en       (lt_en),
    .lt_addr     (lt_addr),
    .rt_en       (rt_en),
    .rt_addr     (rt_addr),
    .lt_busy_n   (lt_busy_n),
    .rt_busy_n   (rt_busy_n),
    .clash_pulse (clash_pulse)
);

// File: tb/test_contention_arbiter.sv
module test_contention_arbiter;

    localparam int AW = 11;
    localparam int NV = 17;

    typedef struct packed {
        logic          le;
        logic [AW-1:0] la;
        logic          ls;
        logic          re;
        logic [AW-1:0] ra;
        logic          rs;
        logic          xlb;
        logic          xrb;
        logic          xp;
    } vec_t;

    // le, la, ls, re, ra, rs | expected lt_busy_n, rt_busy_n, flag
    localparam vec_t VEC [NV] = '{
        '{1'b0, 11'd0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R1 idle
        '{1'b1, 11'd5, 1'b0, 1'b0, 11'd5, 1'b0, 1'b1, 1'b1, 1'b0}, // R1 right off
        '{1'b1, 11'd5, 1'b0, 1'b1, 11'd5, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 R4 enable rise, left earlier
        '{1'b1, 11'd5, 1'b0, 1'b1, 11'd5, 1'b0, 1'b1, 1'b0, 1'b0}, // R8 flag drops
        '{1'b1, 11'd5, 1'b1, 1'b1, 11'd5, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 winner strobe
        '{1'b1, 11'd5, 1'b0, 1'b1, 11'd5, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 loser strobe
        '{1'b1, 11'd5, 1'b0, 1'b1, 11'd6, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 address mismatch
        '{1'b1, 11'd5, 1'b0, 1'b1, 11'd5, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 address change
        '{1'b0, 11'd5, 1'b0, 1'b1, 11'd5, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 enable drop
        '{1'b1, 11'd5, 1'b0, 1'b1, 11'd5, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 right earlier
        '{1'b0, 11'd5, 1'b0, 1'b0, 11'd5, 1'b0, 1'b1, 1'b1, 1'b0}, // R1 both off
        '{1'b1, 11'd9, 1'b0, 1'b1, 11'd9, 1'b0, 1'b1, 1'b0, 1'b1}, // R5 tie on enable
        '{1'b1, 11'd3, 1'b0, 1'b1, 11'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 joint move
        '{1'b0, 11'd3, 1'b0, 1'b0, 11'd3, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 both off
        '{1'b1, 11'd2, 1'b0, 1'b1, 11'd7, 1'b0, 1'b1, 1'b1, 1'b0}, // R1 differ
        '{1'b1, 11'd7, 1'b1, 1'b1, 11'd7, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 tie via strobe
        '{1'b0, 11'd0, 1'b0, 1'b0, 11'd0, 1'b0, 1'b1, 1'b1, 1'b0}  // R6 idle
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lt_en = 1'b0, rt_en = 1'b0;
    logic          lt_start = 1'b0, rt_start = 1'b0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic          lt_busy_n, rt_busy_n, clash_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    contention_arbiter #(.ADDR_W(AW)) i_contention_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .lt_en       (lt_en),
        .lt_addr     (lt_addr),
        .lt_start    (lt_start),
        .rt_en       (rt_en),
        .rt_addr     (rt_addr),
        .rt_start    (rt_start),
        .lt_busy_n   (lt_busy_n),
        .rt_busy_n   (rt_busy_n),
        .clash_pulse (clash_pulse)
    );

    task automatic check3(input string req, input logic xlb, input logic xrb, input logic xp);
        checks++;
        if (lt_busy_n !== xlb || rt_busy_n !== xrb || clash_pulse !== xp) begin
            errors++;
            $display("FAIL %s: got lb=%b rb=%b flag=%b, expected lb=%b rb=%b flag=%b",
                     req, lt_busy_n, rt_busy_n, clash_pulse, xlb, xrb, xp);
        end
    endtask

    task automatic drive(input logic le, input logic [AW-1:0] la, input logic ls,
                         input logic re, input logic [AW-1:0] ra, input logic rs);
        lt_en = le; lt_addr = la; lt_start = ls;
        rt_en = re; rt_addr = ra; rt_start = rs;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check3("R9 reset", 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;

        // Table walk: drive on a falling edge, read on the next one.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].le, VEC[i].la, VEC[i].ls, VEC[i].re, VEC[i].ra, VEC[i].rs);
            @(negedge clk);
            check3($sformatf("table row %0d (R1..R8 as tagged)", i),
                   VEC[i].xlb, VEC[i].xrb, VEC[i].xp);
        end

        // R3: right wins, then left's strobe must not steal the grant (R7).
        drive(1'b0, 11'd0, 1'b0, 1'b1, 11'd40, 1'b0);
        @(negedge clk);
        drive(1'b1, 11'd40, 1'b0, 1'b1, 11'd40, 1'b0);
        @(negedge clk);
        check3("R3 right holds", 1'b0, 1'b1, 1'b1);
        drive(1'b1, 11'd40, 1'b1, 1'b1, 11'd40, 1'b1);
        @(negedge clk);
        check3("R7 both strobe during hold", 1'b0, 1'b1, 1'b0);

        // R9: reset in the middle of a held contention, match kept.
        rst_n = 1'b0;
        #1;
        check3("R9 reset clears busy", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R9 post-reset tie to left", 1'b1, 1'b0, 1'b1);
        // R6: right's address moves away.
        drive(1'b1, 11'd40, 1'b0, 1'b1, 11'd41, 1'b0);
        @(negedge clk);
        check3("R6 release after move", 1'b1, 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule